// File: doc/BRIEF.md
# Exception Context Save Register Unit

This unit is the bank of control and system registers that a processor core uses to keep its context across an exception or interrupt. When the core signals an exception, it hands over the current status word, the faulting instruction address and the stack pointer (general register 15). The unit stores all three in one clock edge, in a saved-status, a saved-address and a saved-stack register. It also holds a vector base, a debug base, a global base, a return-address register that subroutine calls fill, and the fetch address register.

The unit always drives the base address for the exception handler. That base comes from the vector base register, or from the debug base register when user-break debugging is enabled. Software reaches every register through a single read/write port. The five context and base registers that guard the machine are open only in privileged mode. An access to one of them from user mode is refused, and the refusal raises a one-cycle violation flag.

Top module: `ctx_save_unit`

## Requirements
- R1: After reset, the fetch address reads 0xA000_0000, the handler base reads 0x0000_0000 (vector base cleared) and the violation flag is low.
- R2: An exception strobe copies the status word, the faulting address and register 15 into the saved-status (index 0), saved-address (index 1) and saved-stack (index 2) registers, all at the next rising edge.
- R3: When an exception strobe and a port write to a saved register fall in the same cycle, the saved register takes the exception value.
- R4: The handler base is combinational. It equals the vector base (index 3) while the debug enable input is 0 and the debug base (index 4) while it is 1.
- R5: A call strobe loads the return address into the return register (index 6), which drives the return target output. A call wins over a same-cycle port write to index 6.
- R6: A user-mode write to a guarded register (indices 0 to 4) leaves that register unchanged. The violation flag goes high in the following cycle and stays high for that one cycle only.
- R7: A user-mode read of a guarded register returns zero on the read data and raises the violation flag in the following cycle.
- R8: The global base (index 5), the return register (index 6) and the fetch address (index 7, also driven on its own output) can be read and written in either mode without a violation. Privileged accesses to any index never raise the flag.
- R9: Port writes take effect at the next rising edge. Read data is combinational from the selected register while the read strobe is high, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception or interrupt capture strobe |
| exc_sr | input | XLEN | Current status word to save |
| exc_pc | input | XLEN | Address of the faulting instruction |
| exc_r15 | input | XLEN | Current register 15 value |
| call_valid | input | 1 | Subroutine call strobe |
| call_ret | input | XLEN | Return address of the call |
| dbg_brk_en | input | 1 | User-break debug enable, selects the debug base |
| priv_mode | input | 1 | 1 = privileged, 0 = user |
| reg_wr | input | 1 | Port write strobe |
| reg_rd | input | 1 | Port read strobe |
| reg_sel | input | IW | Register index 0..7 |
| reg_wdata | input | XLEN | Port write data |
| reg_rdata | output | XLEN | Port read data |
| acc_viol | output | 1 | One-cycle access violation flag |
| hdl_base | output | XLEN | Exception handler branch base |
| ret_target | output | XLEN | Return register contents |
| pc_q | output | XLEN | Fetch address register |

## Verification
The assertions check the rules that hold on every cycle: a refused access always raises the flag one cycle later, a permitted access never does, and a refused read always returns zero. They also check that a call lands in the return register and that the handler base stays put unless its selector or a base register changes. The three-way capture on an exception, the precedence of capture over a port write, the choice between the two bases, and the reset values can only be shown by the bench's scenarios, which read the registers back through the port.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 8;

    typedef enum logic [2:0] {
        IDX_SSAVE   = 3'd0,
        IDX_PCSAVE  = 3'd1,
        IDX_R15SAVE = 3'd2,
        IDX_VBASE   = 3'd3,
        IDX_DBASE   = 3'd4,
        IDX_GBASE   = 3'd5,
        IDX_RETADDR = 3'd6,
        IDX_FETCH   = 3'd7
    } ctx_idx_e;

    localparam logic [31:0] FETCH_RESET = 32'hA000_0000;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_OK    = 2'd1,
        ACC_DENY  = 2'd2
    } acc_res_e;

    function automatic logic is_guarded(input int idx);
        return (idx <= int'(IDX_DBASE));
    endfunction

    function automatic logic [31:0] reset_word(input int idx);
        return (idx == int'(IDX_FETCH)) ? FETCH_RESET : 32'h0;
    endfunction

endpackage

// File: rtl/ctx_access_ctrl.sv
module ctx_access_ctrl
    import ctx_pkg::*;
#(
    parameter int NREG = ctx_pkg::NREG,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            wr,
    input  logic            rd,
    input  logic            priv,
    input  logic [IW-1:0]   sel,
    output logic [NREG-1:0] wr_onehot,
    output logic            rd_ok,
    output acc_res_e        result
);

    logic guarded;
    logic deny;

    always_comb begin
        guarded = is_guarded(int'(sel));
        deny    = (wr | rd) & ~priv & guarded;
        rd_ok   = rd & ~deny;
        wr_onehot = '0;
        if (wr && !deny) begin
            wr_onehot[sel] = 1'b1;
        end
        if (deny) begin
            result = ACC_DENY;
        end else if (wr || rd) begin
            result = ACC_OK;
        end else begin
            result = ACC_NONE;
        end
    end

endmodule

// File: rtl/ctx_bank.sv
module ctx_bank
    import ctx_pkg::*;
#(
    parameter int XLEN = ctx_pkg::XLEN,
    parameter int NREG = ctx_pkg::NREG
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NREG-1:0]           cap_en,
    input  logic [NREG-1:0][XLEN-1:0] cap_data,
    input  logic [NREG-1:0]           wr_en,
    input  logic [XLEN-1:0]           wdata,
    output logic [NREG-1:0][XLEN-1:0] q
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [XLEN-1:0] RST_VAL = XLEN'(reset_word(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= RST_VAL;
            end else if (cap_en[i]) begin
                q[i] <= cap_data[i];
            end else if (wr_en[i]) begin
                q[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/ctx_base_sel.sv
module ctx_base_sel #(
    parameter int XLEN = ctx_pkg::XLEN
) (
    input  logic            dbg_en,
    input  logic [XLEN-1:0] vbase,
    input  logic [XLEN-1:0] dbase,
    output logic [XLEN-1:0] base
);

    always_comb begin
        base = dbg_en ? dbase : vbase;
    end

endmodule

// File: rtl/ctx_save_unit.sv
module ctx_save_unit
    import ctx_pkg::*;
#(
    parameter int XLEN = ctx_pkg::XLEN,
    parameter int NREG = ctx_pkg::NREG,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_valid,
    input  logic [XLEN-1:0] exc_sr,
    input  logic [XLEN-1:0] exc_pc,
    input  logic [XLEN-1:0] exc_r15,
    input  logic            call_valid,
    input  logic [XLEN-1:0] call_ret,
    input  logic            dbg_brk_en,
    input  logic            priv_mode,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [IW-1:0]   reg_sel,
    input  logic [XLEN-1:0] reg_wdata,
    output logic [XLEN-1:0] reg_rdata,
    output logic            acc_viol,
    output logic [XLEN-1:0] hdl_base,
    output logic [XLEN-1:0] ret_target,
    output logic [XLEN-1:0] pc_q
);

    logic [NREG-1:0]           wr_onehot;
    logic                      rd_ok;
    acc_res_e                  acc_res;
    logic [NREG-1:0]           cap_en;
    logic [NREG-1:0][XLEN-1:0] cap_data;
    logic [NREG-1:0][XLEN-1:0] regs;

    ctx_access_ctrl #(.NREG(NREG)) u_acc (
        .wr        (reg_wr),
        .rd        (reg_rd),
        .priv      (priv_mode),
        .sel       (reg_sel),
        .wr_onehot (wr_onehot),
        .rd_ok     (rd_ok),
        .result    (acc_res)
    );

    // Hardware capture sources; these override port writes in the bank.
    always_comb begin
        cap_en   = '0;
        cap_data = '0;
        cap_en[IDX_SSAVE]     = exc_valid;
        cap_data[IDX_SSAVE]   = exc_sr;
        cap_en[IDX_PCSAVE]    = exc_valid;
        cap_data[IDX_PCSAVE]  = exc_pc;
        cap_en[IDX_R15SAVE]   = exc_valid;
        cap_data[IDX_R15SAVE] = exc_r15;
        cap_en[IDX_RETADDR]   = call_valid;
        cap_data[IDX_RETADDR] = call_ret;
    end

    ctx_bank #(.XLEN(XLEN), .NREG(NREG)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cap_data (cap_data),
        .wr_en    (wr_onehot),
        .wdata    (reg_wdata),
        .q        (regs)
    );

    ctx_base_sel #(.XLEN(XLEN)) u_base (
        .dbg_en (dbg_brk_en),
        .vbase  (regs[IDX_VBASE]),
        .dbase  (regs[IDX_DBASE]),
        .base   (hdl_base)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_viol <= 1'b0;
        end else begin
            acc_viol <= (acc_res == ACC_DENY);
        end
    end

    always_comb begin
        reg_rdata  = rd_ok ? regs[reg_sel] : '0;
        ret_target = regs[IDX_RETADDR];
        pc_q       = regs[IDX_FETCH];
    end

endmodule

// File: rtl/ctx_save_chk.sv
module ctx_save_chk #(
    parameter int XLEN = ctx_pkg::XLEN,
    parameter int NREG = ctx_pkg::NREG,
    localparam int IW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst,
    input logic            call_valid,
    input logic [XLEN-1:0] call_ret,
    input logic            dbg_brk_en,
    input logic            priv_mode,
    input logic            reg_wr,
    input logic            reg_rd,
    input logic [IW-1:0]   reg_sel,
    input logic [XLEN-1:0] reg_rdata,
    input logic            acc_viol,
    input logic [XLEN-1:0] hdl_base,
    input logic [XLEN-1:0] ret_target
);

    logic refused;
    logic base_write;

    always_comb begin
        refused    = (reg_wr || reg_rd) && !priv_mode && (int'(reg_sel) < 5);
        base_write = reg_wr && priv_mode && (int'(reg_sel) == 3 || int'(reg_sel) == 4);
    end

    AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (rst)
        refused |=> acc_viol);                                           // R6

    AST_NO_FALSE_FLAG: assert property (@(posedge clk) disable iff (rst)
        !refused |=> !acc_viol);                                         // R8

    AST_DENY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && refused) |-> (reg_rdata == '0));                      // R7

    AST_CALL_LANDS: assert property (@(posedge clk) disable iff (rst)
        call_valid |=> (ret_target == $past(call_ret)));                 // R5

    AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($stable(dbg_brk_en) && !$past(base_write)) |-> $stable(hdl_base)); // R4

endmodule

bind ctx_save_unit ctx_save_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (.*);

// File: tb/sim_ctx_save_unit.sv
module sim_ctx_save_unit;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;

    typedef enum {SIG_RDATA, SIG_VIOL, SIG_BASE, SIG_RET, SIG_PC} sig_e;
    typedef struct {
        int          due;
        sig_e        sig;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            exc_valid, call_valid, dbg_brk_en, priv_mode, reg_wr, reg_rd;
    logic [XLEN-1:0] exc_sr, exc_pc, exc_r15, call_ret, reg_wdata;
    logic [2:0]      reg_sel;
    logic [XLEN-1:0] reg_rdata, hdl_base, ret_target, pc_q;
    logic            acc_viol;

    item_t sb[$];
    int    cyc = 0;
    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 0;

    ctx_save_unit u0 (
        .clk(clk), .rst(rst),
        .exc_valid(exc_valid), .exc_sr(exc_sr), .exc_pc(exc_pc), .exc_r15(exc_r15),
        .call_valid(call_valid), .call_ret(call_ret),
        .dbg_brk_en(dbg_brk_en), .priv_mode(priv_mode),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .acc_viol(acc_viol), .hdl_base(hdl_base),
        .ret_target(ret_target), .pc_q(pc_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops items due in this cycle and compares them.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.sig)
                SIG_RDATA: act = reg_rdata;
                SIG_VIOL:  act = {31'b0, acc_viol};
                SIG_BASE:  act = hdl_base;
                SIG_RET:   act = ret_target;
                default:   act = pc_q;
            endcase
            vectors++;
            if (act !== it.exp) begin
                miscompares++;
                $display("FAIL %s %s: actual %h expected %h", it.req, it.sig.name(), act, it.exp);
            end
        end
    end

    task automatic clear();
        exc_valid = 0; call_valid = 0; reg_wr = 0; reg_rd = 0;
        priv_mode = 1; reg_sel = 0; reg_wdata = 0;
        exc_sr = 0; exc_pc = 0; exc_r15 = 0; call_ret = 0;
    endtask

    task automatic expect_at(sig_e s, logic [31:0] e, string r);
        item_t it;
        it.due = cyc + 1; it.sig = s; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
        clear();
    endtask

    task automatic wr(logic p, logic [2:0] s, logic [31:0] d);
        priv_mode = p; reg_wr = 1; reg_sel = s; reg_wdata = d;
    endtask

    task automatic rd(logic p, logic [2:0] s);
        priv_mode = p; reg_rd = 1; reg_sel = s;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        dbg_brk_en = 0;
        clear();
        repeat (3) @(negedge clk);
        #1 rst = 0;

        // R1 reset values
        expect_at(SIG_PC, 32'hA000_0000, "R1");
        expect_at(SIG_BASE, 32'h0, "R1");
        expect_at(SIG_VIOL, 32'h0, "R1");
        step();

        // R4/R9 vector base write, then debug base
        wr(1, 3'd3, 32'h8C00_0000);
        expect_at(SIG_BASE, 32'h8C00_0000, "R9");
        expect_at(SIG_VIOL, 32'h0, "R8");
        step();
        wr(1, 3'd4, 32'h1234_0000);
        expect_at(SIG_BASE, 32'h8C00_0000, "R4");
        step();
        dbg_brk_en = 1;
        expect_at(SIG_BASE, 32'h1234_0000, "R4");
        step();
        dbg_brk_en = 0;
        expect_at(SIG_BASE, 32'h8C00_0000, "R4");
        step();

        // R2 three-way capture
        exc_valid = 1; exc_sr = 32'h7000_00F0; exc_pc = 32'h8C00_1234; exc_r15 = 32'h7FFF_FFF0;
        step();
        rd(1, 3'd0); expect_at(SIG_RDATA, 32'h7000_00F0, "R2"); step();
        rd(1, 3'd1); expect_at(SIG_RDATA, 32'h8C00_1234, "R2"); step();
        rd(1, 3'd2); expect_at(SIG_RDATA, 32'h7FFF_FFF0, "R2"); step();

        // R3 capture beats same-cycle write
        exc_valid = 1; exc_sr = 32'h1111_1111; exc_pc = 32'h2222_2222; exc_r15 = 32'h3333_3333;
        wr(1, 3'd0, 32'hDEAD_BEEF);
        step();
        rd(1, 3'd0); expect_at(SIG_RDATA, 32'h1111_1111, "R3"); step();

        // R5 call strobe, call vs write, plain write
        call_valid = 1; call_ret = 32'h8C00_0100;
        expect_at(SIG_RET, 32'h8C00_0100, "R5");
        step();
        call_valid = 1; call_ret = 32'h8C00_0200;
        wr(1, 3'd6, 32'h0000_0055);
        expect_at(SIG_RET, 32'h8C00_0200, "R5");
        step();
        wr(1, 3'd6, 32'hABCD_0000);
        expect_at(SIG_RET, 32'hABCD_0000, "R5");
        step();

        // R6 user write to guarded register refused
        wr(0, 3'd3, 32'hFFFF_0000);
        expect_at(SIG_VIOL, 32'h1, "R6");
        expect_at(SIG_BASE, 32'h8C00_0000, "R6");
        step();
        expect_at(SIG_VIOL, 32'h0, "R6");
        step();
        rd(1, 3'd3); expect_at(SIG_RDATA, 32'h8C00_0000, "R6"); step();

        // R7 user read of guarded register
        rd(0, 3'd1);
        expect_at(SIG_RDATA, 32'h0, "R7");
        expect_at(SIG_VIOL, 32'h1, "R7");
        step();

        // R8 open registers in user mode
        wr(0, 3'd5, 32'h0BAD_F00D);
        expect_at(SIG_VIOL, 32'h0, "R8");
        step();
        rd(0, 3'd5);
        expect_at(SIG_RDATA, 32'h0BAD_F00D, "R8");
        expect_at(SIG_VIOL, 32'h0, "R8");
        step();
        wr(0, 3'd7, 32'h8000_1000);
        expect_at(SIG_PC, 32'h8000_1000, "R8");
        step();
        rd(0, 3'd6);
        expect_at(SIG_RDATA, 32'hABCD_0000, "R8");
        step();

        // R9 no read strobe gives zero
        reg_sel = 3'd5;
        expect_at(SIG_RDATA, 32'h0, "R9");
        step();

        step();
        if (sb.size() != 0) begin
            miscompares++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule